// File: doc/BRIEF.md
# Serial Converter Power-Mode Front End

This block is the digital serial side of a 12-bit sampling converter that can power itself down between conversions. A host drives a chip-select (active low), a serial clock and a serial data line. The block oversamples all three with its own system clock. Each 16-clock frame does two things. It takes in a control byte on the first eight rising serial-clock edges. It sends out a 16-bit word, made of four zero bits followed by the 12-bit result, most significant bit first. The analog conversion itself is not modelled: the block takes the result from a parallel input at the sampling instant.

The control byte carries a two-bit power mode, and that mode takes effect when the frame completes. One mode keeps the block powered. One drops it into full shutdown, which needs a long timed wake-up. One drops it into standby, which wakes within a few cycles. Wake-up starts on the first falling serial-clock edge of the next frame. If the sampling edge comes before wake-up has finished, a status output marks that result as invalid. A frame cut short by raising chip-select has no effect on the power mode.

Top module: `adc_pm_if`

## Requirements
- R1: After synchronous reset, pwr_state is 2'b00 (powered), dout is 0 and result_valid is 0.
- R2: While cs_n stays high, dout is 0.
- R3: Within a frame, dout carries the 16-bit word {4'b0, result}, most significant bit first. Bit 0 is driven from the falling edge of cs_n. Bit i (i ≥ 1) is driven after the i-th rising sclk edge. The host samples each bit on the following falling sclk edge.
- R4: The result in the word is the value of conv_data at the 2nd rising sclk edge of the frame.
- R5: din is sampled on rising sclk edges 1 to 8. The 7th bit is the high mode bit and the 8th bit is the low mode bit. At the 16th rising edge, mode 2'b10 puts pwr_state into 2'b10 (shutdown) and mode 2'b11 puts it into 2'b11 (standby).
- R6: Mode 2'b01 (and the unused code 2'b00) leaves the power state unchanged at the 16th rising edge, so a powered block stays powered (2'b00).
- R7: From shutdown, the first falling sclk edge after cs_n falls moves pwr_state to 2'b01 (waking). The block becomes powered WAKE_SD_CYC cycles later. Holding cs_n low without sclk edges does not leave shutdown.
- R8: From standby, the same first falling edge starts a wake-up of WAKE_SB_CYC cycles through state 2'b01.
- R9: At the 2nd rising sclk edge, result_valid becomes 1 if the block is fully powered and 0 if it is still waking. It holds that value until the next sampling edge.
- R10: Raising cs_n before the 16th rising sclk edge aborts the frame, and its mode bits are not applied. Once any wake-up has run out, the block is powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial control data, sampled on rising sclk |
| conv_data | input | 12 | Parallel conversion result, captured at the sampling edge |
| dout | output | 1 | Serial result data |
| pwr_state | output | 2 | 00 powered, 01 waking, 10 shutdown, 11 standby |
| result_valid | output | 1 | Last sample was taken while fully powered |

## Verification
The bench sets the shutdown wake-up to 40 cycles and the standby wake-up to 3 cycles, in place of the long defaults. The serial half-period then ranges from 2 to 20 system cycles. This puts the sampling edge on both sides of the shutdown wake-up window, with half-periods of 13 and 14 sitting just either side of it. It also shows that standby always wakes in time. The short windows keep every frame, including aborts that are followed by a full wake-up, well inside the run length.

// File: rtl/adc_pm_pkg.sv
// Package: shared encodings for the serial converter power-mode front end.
// Assumes: two-bit power mode field; state codes are visible on the top port.
package adc_pm_pkg;

    typedef enum logic [1:0] {
        PWR_ON   = 2'b00,
        PWR_WAKE = 2'b01,
        PWR_SHUT = 2'b10,
        PWR_STBY = 2'b11
    } pwr_state_t;

    localparam logic [1:0] MODE_SHUT = 2'b10;
    localparam logic [1:0] MODE_STBY = 2'b11;

endpackage

// File: rtl/adc_pm_edges.sv
// Module: adc_pm_edges
// Detects sclk rising/falling edges and the cs_n falling edge by comparing
// each pin against its value one system clock earlier.
// Assumes: pins are already synchronous to clk; sclk idles high.
module adc_pm_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall
);

    logic sclk_d;
    logic cs_d;

    // Hold previous pin levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk;
            cs_d   <= cs_n;
        end
    end

    // Edge pulses, one system cycle wide.
    always_comb begin
        sclk_rise = sclk & ~sclk_d;
        sclk_fall = ~sclk & sclk_d;
        cs_fall   = ~cs_n & cs_d;
    end

endmodule

// File: rtl/adc_pm_frame.sv
// Module: adc_pm_frame
// Frame sequencer: counts rising sclk edges, shifts the control byte in,
// captures the result at the sampling edge and serialises the output word.
// Emits one-cycle pulses for wake request, sampling instant and frame end.
// Assumes: frame ends early if cs_n rises; the mode field is the last two
// control bits shifted in.
module adc_pm_frame #(
    parameter int FRAME_BITS  = 16,
    parameter int CTRL_BITS   = 8,
    parameter int RES_W       = 12,
    parameter int SAMPLE_EDGE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             cs_fall,
    input  logic             din,
    input  logic [RES_W-1:0] conv_data,
    output logic             dout,
    output logic             wake_req,
    output logic             sample_pls,
    output logic             eoc_pls,
    output logic [1:0]       new_mode
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam int LEAD  = FRAME_BITS - RES_W;

    localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_SAMPLE = CNT_W'(SAMPLE_EDGE - 1);
    localparam logic [CNT_W-1:0] CNT_CTRL   = CNT_W'(CTRL_BITS);
    localparam logic [CNT_W-1:0] CNT_FULL   = CNT_W'(FRAME_BITS);

    logic [CNT_W-1:0]      cnt;
    logic [CNT_W-1:0]      nxt;
    logic [CNT_W-1:0]      sel;
    logic                  first_pend;
    logic [CTRL_BITS-1:0]  ctrl_sh;
    logic [RES_W-1:0]      res_q;
    logic [FRAME_BITS-1:0] word;
    logic                  next_bit;
    logic                  live_rise;

    // Frame events derived from the edge pulses and the rise count.
    always_comb begin
        live_rise  = ~cs_n & ~cs_fall & sclk_rise & (cnt < CNT_FULL);
        wake_req   = ~cs_n & ~cs_fall & sclk_fall & first_pend;
        sample_pls = live_rise & (cnt == CNT_SAMPLE);
        eoc_pls    = live_rise & (cnt == CNT_LAST);
        new_mode   = ctrl_sh[1:0];
    end

    // Select the output bit that follows the current rising edge.
    always_comb begin
        word     = {{LEAD{1'b0}}, (sample_pls ? conv_data : res_q)};
        nxt      = cnt + 1'b1;
        sel      = CNT_LAST - nxt;
        next_bit = (nxt < CNT_FULL) ? word[sel[IDX_W-1:0]] : 1'b0;
    end

    // Frame counter, control shift, result capture and serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            first_pend <= 1'b0;
            ctrl_sh    <= '0;
            res_q      <= '0;
            dout       <= 1'b0;
        end else if (cs_n) begin
            cnt        <= '0;
            first_pend <= 1'b0;
            dout       <= 1'b0;
        end else if (cs_fall) begin
            cnt        <= '0;
            first_pend <= 1'b1;
            dout       <= 1'b0;
        end else begin
            if (wake_req) begin
                first_pend <= 1'b0;
            end
            if (live_rise) begin
                cnt  <= nxt;
                dout <= next_bit;
                if (cnt < CNT_CTRL) begin
                    ctrl_sh <= {ctrl_sh[CTRL_BITS-2:0], din};
                end
                if (sample_pls) begin
                    res_q <= conv_data;
                end
            end
        end
    end

endmodule

// File: rtl/adc_pm_power.sv
// Module: adc_pm_power
// Power state machine with wake-up timer and sample validity flag.
// Assumes: WAKE_SB_CYC <= WAKE_SD_CYC; wake_req, sample_pls and eoc_pls are
// single-cycle pulses; frame end and wake request never coincide.
module adc_pm_power
    import adc_pm_pkg::*;
#(
    parameter int WAKE_SD_CYC = 1000,
    parameter int WAKE_SB_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_req,
    input  logic       sample_pls,
    input  logic       eoc_pls,
    input  logic [1:0] new_mode,
    output pwr_state_t state,
    output logic       result_valid
);

    localparam int TMR_W = $clog2(WAKE_SD_CYC + 1);

    logic [TMR_W-1:0] tmr;

    // Mode changes at frame end, wake-up on request, countdown while waking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PWR_ON;
            tmr   <= '0;
        end else if (eoc_pls) begin
            if (new_mode == MODE_SHUT) begin
                state <= PWR_SHUT;
            end else if (new_mode == MODE_STBY) begin
                state <= PWR_STBY;
            end
        end else if (wake_req && state == PWR_SHUT) begin
            state <= PWR_WAKE;
            tmr   <= TMR_W'(WAKE_SD_CYC);
        end else if (wake_req && state == PWR_STBY) begin
            state <= PWR_WAKE;
            tmr   <= TMR_W'(WAKE_SB_CYC);
        end else if (state == PWR_WAKE) begin
            if (tmr <= TMR_W'(1)) begin
                state <= PWR_ON;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end
    end

    // Record whether the sampling edge found the block fully powered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
        end else if (sample_pls) begin
            result_valid <= (state == PWR_ON);
        end
    end

endmodule

// File: rtl/adc_pm_if.sv
// Module: adc_pm_if (top)
// Serial front end of a sampling converter with selectable power-down modes.
// Wires the edge detector, frame sequencer and power state machine.
// Assumes: all pins synchronous to clk; sclk half-period of two or more
// system cycles.
module adc_pm_if #(
    parameter int FRAME_BITS  = 16,
    parameter int CTRL_BITS   = 8,
    parameter int RES_W       = 12,
    parameter int SAMPLE_EDGE = 2,
    parameter int WAKE_SD_CYC = 1000,
    parameter int WAKE_SB_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] conv_data,
    output logic             dout,
    output logic [1:0]       pwr_state,
    output logic             result_valid
);

    import adc_pm_pkg::*;

    logic       sclk_rise;
    logic       sclk_fall;
    logic       cs_fall;
    logic       wake_req;
    logic       sample_pls;
    logic       eoc_pls;
    logic [1:0] new_mode;
    pwr_state_t state;

    adc_pm_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall)
    );

    adc_pm_frame #(
        .FRAME_BITS  (FRAME_BITS),
        .CTRL_BITS   (CTRL_BITS),
        .RES_W       (RES_W),
        .SAMPLE_EDGE (SAMPLE_EDGE)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .cs_fall    (cs_fall),
        .din        (din),
        .conv_data  (conv_data),
        .dout       (dout),
        .wake_req   (wake_req),
        .sample_pls (sample_pls),
        .eoc_pls    (eoc_pls),
        .new_mode   (new_mode)
    );

    adc_pm_power #(
        .WAKE_SD_CYC (WAKE_SD_CYC),
        .WAKE_SB_CYC (WAKE_SB_CYC)
    ) u_power (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_req     (wake_req),
        .sample_pls   (sample_pls),
        .eoc_pls      (eoc_pls),
        .new_mode     (new_mode),
        .state        (state),
        .result_valid (result_valid)
    );

    // Expose the power state on the port.
    always_comb pwr_state = state;

endmodule

// File: rtl/adc_pm_if_chk.sv
// Module: adc_pm_if_chk
// Port-level temporal checks for adc_pm_if, attached with bind below.
// Assumes: synchronous active-low reset; pins stable between clk edges.
module adc_pm_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       dout,
    input logic [1:0] pwr_state,
    input logic       result_valid
);

    // R2: output stays low once chip-select has been high for a cycle.
    a_r2_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !dout);

    // R7: shutdown is only ever left through the waking state.
    a_r7_shut_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b10) |=> (pwr_state == 2'b10 || pwr_state == 2'b01));

    // R8: standby is only ever left through the waking state.
    a_r8_stby_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b11) |=> (pwr_state == 2'b11 || pwr_state == 2'b01));

    // R6: a powered block never starts a wake-up directly.
    a_r6_on_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b00) |=> (pwr_state != 2'b01));

    // R9: the validity flag only moves on a rising sclk inside a frame.
    a_r9_valid_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_valid) |-> ($past(sclk) && !$past(sclk, 2) && !$past(cs_n)));

endmodule

bind adc_pm_if adc_pm_if_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .dout         (dout),
    .pwr_state    (pwr_state),
    .result_valid (result_valid)
);

// File: tb/adc_pm_if_tb_top.sv
`timescale 1ns/1ps
// Bench for adc_pm_if: directed corner frames plus seeded random frames,
// compared against a behavioural power/validity model kept in the bench.
module adc_pm_if_tb_top;

    localparam int WSD = 40;
    localparam int WSB = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n;
    logic        sclk;
    logic        din;
    logic [11:0] conv_data;
    logic        dout;
    logic [1:0]  pwr_state;
    logic        result_valid;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [1:0] m_pwr;
    logic       m_valid;

    always #2.5 clk = ~clk;

    adc_pm_if #(
        .WAKE_SD_CYC (WSD),
        .WAKE_SB_CYC (WSB)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .din          (din),
        .conv_data    (conv_data),
        .dout         (dout),
        .pwr_state    (pwr_state),
        .result_valid (result_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Validity of a sample taken 3*h cycles after the wake request.
    function automatic logic exp_valid(input logic [1:0] st, input int h);
        if (st == 2'b10) return (3 * h >= WSD + 1);
        if (st == 2'b11) return (3 * h >= WSB + 1);
        return 1'b1;
    endfunction

    // Power state after a frame: mode decides on completion, abort wakes.
    function automatic logic [1:0] exp_pwr(input logic [1:0] mode, input int abort_k);
        if (abort_k != 0) return 2'b00;
        if (mode == 2'b10 || mode == 2'b11) return mode;
        return 2'b00;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame; abort_k = rising edges before cs_n rises (0 = full frame).
    task automatic frame(input logic [1:0] mode, input logic [11:0] data,
                         input int h, input int abort_k, input bit chk_wake);
        logic [7:0]  ctrl;
        logic [15:0] word;
        int          rises;
        ctrl      = {6'($urandom), mode};
        word      = '0;
        rises     = 0;
        conv_data = data;
        @(negedge clk);
        cs_n = 1'b0;
        wait_cyc(h);
        for (int i = 0; i < 16; i++) begin
            if (abort_k != 0 && i == abort_k) break;
            word[15-i] = dout;
            sclk = 1'b0;
            din  = (i < 8) ? ctrl[7-i] : 1'($urandom);
            if (i == 0 && chk_wake && m_pwr != 2'b00) begin
                wait_cyc(2);
                chk("R7/R8 waking after first falling edge", 32'(pwr_state), 32'h1);
                wait_cyc(h - 2);
            end else begin
                wait_cyc(h);
            end
            sclk = 1'b1;
            rises++;
            wait_cyc(h);
        end
        cs_n = 1'b1;
        if (rises >= 2) m_valid = exp_valid(m_pwr, h);
        m_pwr = exp_pwr(mode, abort_k);
        wait_cyc(abort_k != 0 ? WSD + 8 : 4);
        chk(abort_k != 0 ? "R10 abort leaves mode unapplied" : "R5/R6 power state after frame",
            32'(pwr_state), 32'(m_pwr));
        chk("R9 result_valid", 32'(result_valid), 32'(m_valid));
        chk("R2 dout idle", 32'(dout), 32'h0);
        if (abort_k == 0) chk("R3/R4 output word", 32'(word), {20'h0, 4'h0, data});
    endtask

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b0; conv_data = '0;
        m_pwr = 2'b00; m_valid = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 reset pwr_state", 32'(pwr_state), 32'h0);
        chk("R1 reset dout", 32'(dout), 32'h0);
        chk("R1 reset result_valid", 32'(result_valid), 32'h0);

        frame(2'b01, 12'hABC, 4, 0, 0);   // R6 stays powered
        frame(2'b10, 12'h5A5, 3, 0, 0);   // R5 enter shutdown
        @(negedge clk); cs_n = 1'b0;      // R7 cs_n low alone does not wake
        wait_cyc(100);
        chk("R7 shutdown held with cs_n low", 32'(pwr_state), 32'h2);
        cs_n = 1'b1; wait_cyc(10);
        frame(2'b01, 12'hFFF, 13, 0, 1);  // R9 sample inside window
        frame(2'b10, 12'h001, 2, 0, 0);
        frame(2'b10, 12'h800, 14, 0, 1);  // R9 sample just past window
        frame(2'b11, 12'h123, 2, 0, 0);   // shutdown -> standby, invalid
        frame(2'b11, 12'h7E7, 2, 0, 1);   // R8 standby wakes in time
        frame(2'b01, 12'h456, 5, 0, 0);
        frame(2'b10, 12'h321, 3, 12, 0);  // R10 abort after mode bits
        frame(2'b10, 12'h0F0, 6, 0, 0);
        frame(2'b11, 12'h999, 4, 10, 0);  // R10 abort from shutdown
        frame(2'b10, 12'h111, 2, 1, 0);   // R10 abort before sample

        for (int n = 0; n < 120; n++) begin
            frame(2'($urandom), 12'($urandom), $urandom_range(20, 2),
                  ($urandom_range(7, 0) == 0) ? $urandom_range(15, 1) : 0,
                  1'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule